// File: doc/BRIEF.md
# Asynchronous Serial Character Receiver

This block receives characters from one asynchronous serial line. It runs from the system clock and samples the line on a single-cycle enable. The enable pulses at sixteen times the bit rate, and the baud divisor that makes it lives outside this block. A falling edge on the line arms a start check. The check rejects glitches by sampling the line again near the middle of the start bit. A start that is confirmed is followed by 5 to 8 data bits, least significant first. An optional parity bit comes next, then a single stop bit.

Each finished character goes into a one-entry holding register, and the line-status flags are updated with it. The host reads the character, which drops the ready flag, and reads the status separately, which clears the sticky error flags. The format inputs are held steady by the host while a character is in flight.

Top module: `serial_rx_unit`

## Requirements
- R1: While reset is high and in the cycle after it, `rx_byte` is 0x00 and every status output (`st_ready`, `st_overrun`, `st_parity_err`, `st_frame_err`, `st_break`) is 0.
- R2: A low pulse on `rx_in` that returns high before the start-bit midpoint check (8 sample enables after the detected falling edge) produces no character: `st_ready` stays 0 and the receiver goes back to waiting for an edge.
- R3: `fmt_len` selects the number of data bits: 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8. Bits arrive least significant first, and the unused upper bits of `rx_byte` read 0.
- R4: With `fmt_par_en`=1 a parity bit follows the data. `fmt_par_force`=0 with `fmt_par_even`=0 expects odd parity, and `fmt_par_even`=1 expects even parity. `fmt_par_force`=1 with `fmt_par_even`=0 expects a 1, and with `fmt_par_even`=1 expects a 0. A mismatch sets `st_parity_err`.
- R5: A stop bit sampled as 0 sets `st_frame_err`.
- R6: If the line is low for every sampled bit of a frame, including the stop bit, `st_break` is set and 0x00 is loaded. No new start is accepted until the line has returned high.
- R7: `st_ready` is set when a character is loaded into the holding register and cleared by a `rd_data` pulse.
- R8: If a character completes while `st_ready` is 1 and no `rd_data` is present, `st_overrun` is set, the new character and its error flags are dropped, and `rx_byte` keeps its old value.
- R9: `st_overrun`, `st_parity_err`, `st_frame_err` and `st_break` stay set until a `rd_status` pulse, which clears them without changing `st_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_16x | input | 1 | Sample enable, one cycle wide, at 16x the bit rate |
| rx_in | input | 1 | Serial line, idle high |
| fmt_len | input | 2 | Data bit count select (5 + value) |
| fmt_par_en | input | 1 | Parity bit present |
| fmt_par_even | input | 1 | Even parity, or forced 0 when forcing |
| fmt_par_force | input | 1 | Parity bit forced to a constant |
| rd_data | input | 1 | Holding-register read pulse |
| rd_status | input | 1 | Status read pulse, clears error flags |
| rx_byte | output | 8 | Holding-register character |
| st_ready | output | 1 | Character waiting |
| st_overrun | output | 1 | Character lost to a full holding register |
| st_parity_err | output | 1 | Parity mismatch |
| st_frame_err | output | 1 | Stop bit found low |
| st_break | output | 1 | Line held low for a whole frame |

## Verification
The bench builds the block with its default sixteen-fold oversampling and a two-stage synchronizer, and pulses the sample enable once every four clocks. That makes one bit 64 clocks long. Whole frames of every length and parity mode then fit in a short run, and a three-enable glitch falls well short of the eight-enable start check. With those values the bench also reaches a back-to-back overrun and a break held over two frame times.

// File: rtl/srx_pkg.sv
package srx_pkg;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP,
        RX_HOLDLOW
    } rx_state_e;

    typedef struct packed {
        logic [1:0] len;
        logic       par_en;
        logic       par_even;
        logic       par_force;
    } rx_fmt_t;

    typedef struct packed {
        logic [7:0] data;
        logic       par_err;
        logic       frm_err;
        logic       brk;
    } rx_char_t;

    function automatic logic [3:0] data_bits(input logic [1:0] len);
        return 4'd5 + {2'b00, len};
    endfunction

    // Parity bit the sender should have placed after data (upper unused bits zero).
    function automatic logic want_parity(input rx_fmt_t f, input logic [7:0] d);
        if (f.par_force)
            return ~f.par_even;
        else if (f.par_even)
            return ^d;
        else
            return ~(^d);
    endfunction

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic rx_in,
    output logic rx_s,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              prev;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= rx_in;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= {chain[STAGES-2:0], rx_in};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b1;
        else     prev <= chain[STAGES-1];
    end

    assign rx_s = chain[STAGES-1];
    assign fall = prev & ~chain[STAGES-1];
endmodule

// File: rtl/srx_frame.sv
module srx_frame
    import srx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  logic     rx_s,
    input  logic     fall,
    input  rx_fmt_t  fmt,
    output logic     chr_vld,
    output rx_char_t chr
);
    localparam int CW       = $clog2(OVS);
    localparam int START_PT = OVS / 2 - 1;
    localparam int BIT_PT   = OVS - 1;

    rx_state_e    state;
    logic [CW-1:0] cnt;
    logic [7:0]   data;
    logic [2:0]   idx;
    logic         all_low;
    logic         par_bad;
    logic [3:0]   nbits;
    logic         at_start_pt;
    logic         at_bit_pt;

    assign nbits       = data_bits(fmt.len);
    assign at_start_pt = tick && (cnt == CW'(START_PT));
    assign at_bit_pt   = tick && (cnt == CW'(BIT_PT));

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= RX_IDLE;
            cnt     <= '0;
            data    <= '0;
            idx     <= '0;
            all_low <= 1'b0;
            par_bad <= 1'b0;
            chr_vld <= 1'b0;
            chr     <= '0;
        end else begin
            chr_vld <= 1'b0;
            if (tick && !at_bit_pt && state != RX_IDLE && state != RX_HOLDLOW)
                cnt <= cnt + 1'b1;
            case (state)
                RX_IDLE: begin
                    if (fall) begin
                        state <= RX_START;
                        cnt   <= '0;
                    end
                end
                RX_START: begin
                    if (at_start_pt) begin
                        cnt <= '0;
                        if (!rx_s) begin
                            state   <= RX_DATA;
                            data    <= '0;
                            idx     <= '0;
                            all_low <= 1'b1;
                            par_bad <= 1'b0;
                        end else begin
                            state <= RX_IDLE;
                        end
                    end
                end
                RX_DATA: begin
                    if (at_bit_pt) begin
                        cnt       <= '0;
                        data[idx] <= rx_s;
                        all_low   <= all_low & ~rx_s;
                        if ({1'b0, idx} == nbits - 4'd1)
                            state <= fmt.par_en ? RX_PAR : RX_STOP;
                        else
                            idx <= idx + 1'b1;
                    end
                end
                RX_PAR: begin
                    if (at_bit_pt) begin
                        cnt     <= '0;
                        par_bad <= (rx_s != want_parity(fmt, data));
                        all_low <= all_low & ~rx_s;
                        state   <= RX_STOP;
                    end
                end
                RX_STOP: begin
                    if (at_bit_pt) begin
                        cnt         <= '0;
                        chr_vld     <= 1'b1;
                        chr.data    <= data;
                        chr.par_err <= par_bad;
                        chr.frm_err <= ~rx_s;
                        chr.brk     <= all_low & ~rx_s;
                        state       <= (all_low && !rx_s) ? RX_HOLDLOW : RX_IDLE;
                    end
                end
                RX_HOLDLOW: begin
                    if (rx_s) state <= RX_IDLE;
                end
                default: state <= RX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/srx_hold.sv
module srx_hold
    import srx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       chr_vld,
    input  rx_char_t   chr,
    input  logic       rd_data,
    input  logic       rd_status,
    output logic [7:0] rx_byte,
    output logic       st_ready,
    output logic       st_overrun,
    output logic       st_parity_err,
    output logic       st_frame_err,
    output logic       st_break
);
    logic room;
    logic take;
    logic lose;

    assign room = ~st_ready | rd_data;
    assign take = chr_vld & room;
    assign lose = chr_vld & ~room;

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_byte       <= '0;
            st_ready      <= 1'b0;
            st_overrun    <= 1'b0;
            st_parity_err <= 1'b0;
            st_frame_err  <= 1'b0;
            st_break      <= 1'b0;
        end else begin
            if (take) begin
                rx_byte  <= chr.data;
                st_ready <= 1'b1;
            end else if (rd_data) begin
                st_ready <= 1'b0;
            end
            st_overrun    <= (st_overrun    & ~rd_status) | lose;
            st_parity_err <= (st_parity_err & ~rd_status) | (take & chr.par_err);
            st_frame_err  <= (st_frame_err  & ~rd_status) | (take & chr.frm_err);
            st_break      <= (st_break      & ~rd_status) | (take & chr.brk);
        end
    end
endmodule

// File: rtl/serial_rx_unit.sv
module serial_rx_unit
    import srx_pkg::*;
#(
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_16x,
    input  logic       rx_in,
    input  logic [1:0] fmt_len,
    input  logic       fmt_par_en,
    input  logic       fmt_par_even,
    input  logic       fmt_par_force,
    input  logic       rd_data,
    input  logic       rd_status,
    output logic [7:0] rx_byte,
    output logic       st_ready,
    output logic       st_overrun,
    output logic       st_parity_err,
    output logic       st_frame_err,
    output logic       st_break
);
    logic     rx_s;
    logic     fall;
    logic     chr_vld;
    rx_char_t chr;
    rx_fmt_t  fmt;

    assign fmt = '{len: fmt_len, par_en: fmt_par_en, par_even: fmt_par_even,
                   par_force: fmt_par_force};

    srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .rx_in(rx_in),
        .rx_s (rx_s),
        .fall (fall)
    );

    srx_frame #(.OVS(OVS)) u_frame (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick_16x),
        .rx_s   (rx_s),
        .fall   (fall),
        .fmt    (fmt),
        .chr_vld(chr_vld),
        .chr    (chr)
    );

    srx_hold u_hold (
        .clk          (clk),
        .rst          (rst),
        .chr_vld      (chr_vld),
        .chr          (chr),
        .rd_data      (rd_data),
        .rd_status    (rd_status),
        .rx_byte      (rx_byte),
        .st_ready     (st_ready),
        .st_overrun   (st_overrun),
        .st_parity_err(st_parity_err),
        .st_frame_err (st_frame_err),
        .st_break     (st_break)
    );
endmodule

// File: rtl/srx_checker.sv
module srx_checker (
    input logic       clk,
    input logic       rst,
    input logic       chr_vld,
    input logic       rd_data,
    input logic       rd_status,
    input logic [7:0] rx_byte,
    input logic       st_ready,
    input logic       st_overrun,
    input logic       st_parity_err,
    input logic       st_frame_err,
    input logic       st_break
);
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (!st_ready && !st_overrun && !st_parity_err && !st_frame_err
                 && !st_break && rx_byte == 8'h00));

    a_r7_read_drops_ready: assert property (@(posedge clk) disable iff (rst)
        (rd_data && !chr_vld) |=> !st_ready);

    a_r7_ready_needs_char: assert property (@(posedge clk) disable iff (rst)
        $rose(st_ready) |-> $past(chr_vld));

    a_r8_byte_kept_while_full: assert property (@(posedge clk) disable iff (rst)
        (st_ready && !rd_data) |=> $stable(rx_byte));

    a_r9_status_read_clears: assert property (@(posedge clk) disable iff (rst)
        (rd_status && !chr_vld) |=>
            (!st_overrun && !st_parity_err && !st_frame_err && !st_break));

    a_r9_parity_sticky: assert property (@(posedge clk) disable iff (rst)
        (st_parity_err && !rd_status) |=> st_parity_err);

    a_r9_ready_untouched: assert property (@(posedge clk) disable iff (rst)
        (rd_status && !rd_data && !chr_vld) |=> $stable(st_ready));
endmodule

bind serial_rx_unit srx_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .chr_vld      (chr_vld),
    .rd_data      (rd_data),
    .rd_status    (rd_status),
    .rx_byte      (rx_byte),
    .st_ready     (st_ready),
    .st_overrun   (st_overrun),
    .st_parity_err(st_parity_err),
    .st_frame_err (st_frame_err),
    .st_break     (st_break)
);

// File: tb/serial_rx_unit_bench.sv
module serial_rx_unit_bench;
    localparam int BIT_CLKS = 64;   // 16 enables x 4 clocks
    localparam int NVEC     = 8;

    // {len, pen, pev, pfo, badpar, stop, data, exp, exp_pe, exp_fe}
    localparam logic [24:0] VEC [NVEC] = '{
        {2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'hA5, 8'hA5, 1'b0, 1'b0},
        {2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h3F, 8'h1F, 1'b0, 1'b0},
        {2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'h2C, 8'h2C, 1'b0, 1'b0},
        {2'd2, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 8'h55, 8'h55, 1'b1, 1'b0},
        {2'd3, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 8'h81, 8'h81, 1'b0, 1'b0},
        {2'd3, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 8'h7E, 8'h7E, 1'b1, 1'b0},
        {2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h12, 8'h12, 1'b0, 1'b1},
        {2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 8'h00, 1'b0, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_16x = 1'b0;
    logic       rx_in = 1'b1;
    logic [1:0] fmt_len = 2'd3;
    logic       fmt_par_en = 1'b0;
    logic       fmt_par_even = 1'b0;
    logic       fmt_par_force = 1'b0;
    logic       rd_data = 1'b0;
    logic       rd_status = 1'b0;
    logic [7:0] rx_byte;
    logic       st_ready, st_overrun, st_parity_err, st_frame_err, st_break;

    int n_checks = 0;
    int n_fail   = 0;
    int tdiv     = 0;
    bit done     = 0;

    always #4 clk = ~clk;

    always @(negedge clk) begin
        tdiv     = (tdiv + 1) % 4;
        tick_16x = (tdiv == 0);
    end

    serial_rx_unit u_serial_rx_unit (
        .clk(clk), .rst(rst), .tick_16x(tick_16x), .rx_in(rx_in),
        .fmt_len(fmt_len), .fmt_par_en(fmt_par_en), .fmt_par_even(fmt_par_even),
        .fmt_par_force(fmt_par_force), .rd_data(rd_data), .rd_status(rd_status),
        .rx_byte(rx_byte), .st_ready(st_ready), .st_overrun(st_overrun),
        .st_parity_err(st_parity_err), .st_frame_err(st_frame_err),
        .st_break(st_break)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic line(input logic b, input int clks);
        @(negedge clk);
        rx_in = b;
        repeat (clks - 1) @(negedge clk);
    endtask

    task automatic send(input logic [1:0] len, input logic pen, input logic pev,
                        input logic pfo, input logic bad, input logic stop,
                        input logic [7:0] d);
        logic [7:0] m;
        logic       p;
        m = d & ((8'h1 << (5 + len)) - 8'h1);
        if (pfo)      p = ~pev;
        else if (pev) p = ^m;
        else          p = ~(^m);
        p = p ^ bad;
        line(1'b0, BIT_CLKS);
        for (int i = 0; i < 5 + int'(len); i++) line(m[i], BIT_CLKS);
        if (pen) line(p, BIT_CLKS);
        line(stop, BIT_CLKS);
        line(1'b1, BIT_CLKS);
    endtask

    task automatic pulse_rd(input logic dat, input logic sts);
        @(negedge clk);
        rd_data   = dat;
        rd_status = sts;
        @(negedge clk);
        rd_data   = 1'b0;
        rd_status = 1'b0;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        // R1: reset state while held and just after release
        check("R1 ready", {7'd0, st_ready}, 8'd0);
        check("R1 byte", rx_byte, 8'h00);
        rst = 1'b0;
        @(negedge clk);
        check("R1 flags", {4'd0, st_overrun, st_parity_err, st_frame_err, st_break}, 8'd0);
        line(1'b1, BIT_CLKS);

        // R2: glitch of 3 enables is rejected
        line(1'b0, 12);
        line(1'b1, 3 * BIT_CLKS);
        check("R2 glitch no char", {7'd0, st_ready}, 8'd0);

        // Table walk: R3 lengths, R4 parity modes, R5 framing, R7, R9
        for (int v = 0; v < NVEC; v++) begin
            fmt_len       = VEC[v][24:23];
            fmt_par_en    = VEC[v][22];
            fmt_par_even  = VEC[v][21];
            fmt_par_force = VEC[v][20];
            send(VEC[v][24:23], VEC[v][22], VEC[v][21], VEC[v][20], VEC[v][19],
                 VEC[v][18], VEC[v][17:10]);
            check("R3 byte", rx_byte, VEC[v][9:2]);
            check("R7 ready set", {7'd0, st_ready}, 8'd1);
            check("R4 parity flag", {7'd0, st_parity_err}, {7'd0, VEC[v][1]});
            check("R5 frame flag", {7'd0, st_frame_err}, {7'd0, VEC[v][0]});
            check("R6 no break", {7'd0, st_break}, 8'd0);
            pulse_rd(1'b1, 1'b0);
            check("R7 ready cleared", {7'd0, st_ready}, 8'd0);
            check("R9 sticky after data read",
                  {6'd0, st_parity_err, st_frame_err}, {6'd0, VEC[v][1], VEC[v][0]});
            pulse_rd(1'b0, 1'b1);
            check("R9 cleared by status read",
                  {6'd0, st_parity_err, st_frame_err}, 8'd0);
        end

        // R8: overrun keeps the first byte
        fmt_len = 2'd3; fmt_par_en = 1'b0; fmt_par_even = 1'b0; fmt_par_force = 1'b0;
        send(2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h3C);
        send(2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hC3);
        check("R8 old byte kept", rx_byte, 8'h3C);
        check("R8 overrun set", {7'd0, st_overrun}, 8'd1);
        check("R8 dropped char errors", {7'd0, st_frame_err}, 8'd0);
        pulse_rd(1'b0, 1'b1);
        check("R9 overrun cleared", {7'd0, st_overrun}, 8'd0);
        check("R9 ready untouched", {7'd0, st_ready}, 8'd1);
        pulse_rd(1'b1, 1'b0);

        // R6: break held two frame times
        line(1'b0, 20 * BIT_CLKS);
        check("R6 break flag", {7'd0, st_break}, 8'd1);
        check("R6 zero byte", rx_byte, 8'h00);
        check("R6 ready", {7'd0, st_ready}, 8'd1);
        pulse_rd(1'b1, 1'b1);
        check("R6 still low no new char", {7'd0, st_ready}, 8'd0);
        line(1'b1, 2 * BIT_CLKS);
        send(2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h96);
        check("R6 receive after release", rx_byte, 8'h96);
        check("R6 break cleared", {7'd0, st_break}, 8'd0);

        finish_run();
    end
endmodule